// File: doc/BRIEF.md
# Stationary-Operand Integer Matrix Product Array

The block multiplies two square matrices of signed 8-bit integers, C = A x B, on a fully spatial grid of multipliers. The left operand is written once through a wide load port and then stays in place, one element per multiplier. After a start pulse, the right operand arrives one column per cycle. Each column is multiplied against the whole stationary operand in a single cycle, and one complete column of the result appears two cycles later. A dimension-N product therefore takes N input cycles, and back-to-back columns keep every multiplier busy.

The multiplier at grid row r and grid column c holds A[c][r]. Every multiplier in grid row r sees element r of the incoming column. Grid column c thus forms the dot product of row c of A with the incoming column, and the registered products down that grid column are summed into result element c. The result leaves in column-major order. A one-cycle done pulse marks the end of a run. The stationary operand survives from run to run, so one A can be applied to many B matrices without reloading it.

Top module: `matmul_array`

## Requirements
- R1: After reset, cValid, done and cOut are all zero and every held A element is zero. A run started without any load therefore yields all-zero result columns.
- R2: For every accepted column k of B, cOut carries C[i][k] = sum over j of A[i][j]*B[j][k], computed exactly in signed arithmetic. Element i sits at cOut[i*OW +: OW]. A element (i,j) is taken from aIn[(i*N+j)*DW +: DW] and B element j from bIn[j*DW +: DW].
- R3: Result elements are OW = 2*DW + ceil(log2 N) bits wide, signed. Operands that are all -128, all +127, or -128 against +127 produce their exact values with no wrap-around.
- R4: A column accepted at one rising edge appears with cValid high after the second rising edge that follows. Columns accepted on consecutive edges come out on consecutive cycles.
- R5: After start, exactly N columns with bValid high are accepted, and gaps in bValid between them are allowed. Results come out in the order the columns were accepted, one cValid cycle per accepted column.
- R6: done is high for exactly one cycle, in the cycle after the cValid of the N-th column of a run.
- R7: bValid has no effect when no run is active. This includes the cycle in which start itself is sampled.
- R8: loadA is ignored while a run is active, and the held A stays unchanged across runs until the next accepted load.
- R9: start is ignored while a run is active. It neither restarts the column count nor extends the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| loadA | input | 1 | Capture aIn into the stationary operand (idle only) |
| aIn | input | N*N*DW | Matrix A, element (i,j) at offset (i*N+j)*DW |
| start | input | 1 | Begin a run of N columns (idle only) |
| bValid | input | 1 | bIn holds a column of B this cycle |
| bIn | input | N*DW | One column of B, element j at offset j*DW |
| cValid | output | 1 | cOut holds one column of C |
| cOut | output | N*OW | One column of C, element i at offset i*OW |
| done | output | 1 | One-cycle pulse after the last column of a run |

## Verification
The bench targets the extreme operand values. A sum tree that is too narrow, or one that extends products without their sign, returns a wrapped or positive value for the all -128 and mixed-sign cases. It also checks the exact output cycle for back-to-back and gapped columns. A missing or extra pipeline stage shifts every cValid, and a counter that is off by one ends the run early or accepts a fourth column. Inputs are sent at the wrong moments on purpose: bValid while idle or in the start cycle, and loadA or start during a run. A design that failed to gate these would emit stray columns, use the wrong A, or restart its count and move the done pulse.

// File: rtl/matmul_pkg.sv
package matmul_pkg;

  // Strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic loadEn;  // capture the stationary operand
    logic mulEn;   // register the products of the current column
    logic addEn;   // register the column sums
  } strobe_t;

endpackage

// File: rtl/matmul_ctrl.sv
module matmul_ctrl
  import matmul_pkg::*;
#(
  parameter int N = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadA,
  input  logic    start,
  input  logic    bValid,
  output strobe_t strb,
  output logic    busy,
  output logic    accept,
  output logic    cValid,
  output logic    done
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] colCnt;
  logic          prodValid;
  logic          prodLast;
  logic          sumLast;
  logic          isLast;

  assign accept = bValid && busy;
  assign isLast = (colCnt == LAST);

  always_comb begin
    strb        = '0;
    strb.loadEn = loadA && !busy;
    strb.mulEn  = accept;
    strb.addEn  = prodValid;
  end

  // Run tracking: start arms only when idle; the N-th accepted column disarms.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      colCnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        colCnt <= '0;
      end
    end else if (accept) begin
      if (isLast) begin
        busy   <= 1'b0;
        colCnt <= '0;
      end else begin
        colCnt <= colCnt + CW'(1);
      end
    end
  end

  // Valid and last-column tags ride alongside the two datapath stages.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodValid <= 1'b0;
      prodLast  <= 1'b0;
      cValid    <= 1'b0;
      sumLast   <= 1'b0;
      done      <= 1'b0;
    end else begin
      prodValid <= accept;
      prodLast  <= accept && isLast;
      cValid    <= prodValid;
      sumLast   <= prodValid && prodLast;
      done      <= cValid && sumLast;
    end
  end

endmodule

// File: rtl/matmul_dp.sv
module matmul_dp
  import matmul_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 8,
  parameter int OW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [N*N*DW-1:0] aIn,
  input  logic [N*DW-1:0]   bIn,
  output logic [N*OW-1:0]   cOut,
  output logic [N*N*DW-1:0] aView
);

  localparam int PW  = 2 * DW;
  localparam int EXT = OW - PW;

  // Grid cell (r,c) holds A[c][r]; grid row r is fed by B element r.
  logic signed [DW-1:0] aCell   [N][N];
  logic signed [DW-1:0] bElem   [N];
  logic signed [PW-1:0] prodReg [N][N];
  logic signed [OW-1:0] colSum  [N];
  logic signed [OW-1:0] sumReg  [N];

  for (genvar r = 0; r < N; r++) begin : g_bsplit
    assign bElem[r] = bIn[r*DW +: DW];
  end

  for (genvar r = 0; r < N; r++) begin : g_vrow
    for (genvar c = 0; c < N; c++) begin : g_vcol
      assign aView[(c*N+r)*DW +: DW] = aCell[r][c];
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_cpack
    assign cOut[c*OW +: OW] = sumReg[c];
  end

  // Stationary operand.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          aCell[r][c] <= '0;
    end else if (strb.loadEn) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          aCell[r][c] <= aIn[(c*N+r)*DW +: DW];
    end
  end

  // Multiply stage: one registered product per grid cell.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          prodReg[r][c] <= '0;
    end else if (strb.mulEn) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          prodReg[r][c] <= aCell[r][c] * bElem[r];
    end
  end

  // Column adder chains: N-1 two-input adds per grid column after trimming.
  always_comb begin
    for (int c = 0; c < N; c++) begin
      colSum[c] = '0;
      for (int r = 0; r < N; r++)
        colSum[c] = colSum[c] + {{EXT{prodReg[r][c][PW-1]}}, prodReg[r][c]};
    end
  end

  // Add stage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < N; c++)
        sumReg[c] <= '0;
    end else if (strb.addEn) begin
      for (int c = 0; c < N; c++)
        sumReg[c] <= colSum[c];
    end
  end

endmodule

// File: rtl/matmul_array.sv
module matmul_array
  import matmul_pkg::*;
#(
  parameter int N  = 3,
  parameter int DW = 8,
  localparam int OW = 2 * DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadA,
  input  logic [N*N*DW-1:0] aIn,
  input  logic              start,
  input  logic              bValid,
  input  logic [N*DW-1:0]   bIn,
  output logic              cValid,
  output logic [N*OW-1:0]   cOut,
  output logic              done
);

  strobe_t           strb;
  logic              busy;
  logic              accept;
  logic [N*N*DW-1:0] aView;

  matmul_ctrl #(.N(N)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .loadA  (loadA),
    .start  (start),
    .bValid (bValid),
    .strb   (strb),
    .busy   (busy),
    .accept (accept),
    .cValid (cValid),
    .done   (done)
  );

  matmul_dp #(.N(N), .DW(DW), .OW(OW)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .aIn   (aIn),
    .bIn   (bIn),
    .cOut  (cOut),
    .aView (aView)
  );

endmodule

// File: rtl/matmul_chk.sv
module matmul_chk #(
  parameter int N  = 3,
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              accept,
  input logic              cValid,
  input logic              done,
  input logic [N*N*DW-1:0] aView
);

  // R1: reset clears the output strobes
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!cValid && !done));

  // R4: an accepted column appears two edges later
  a_r4_two_cycle_latency: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> ##2 cValid);

  // R5: no result column without an accepted input column
  a_r5_no_orphan_column: assert property (@(posedge clk) disable iff (!rstN)
    cValid |-> $past(accept, 2));

  // R6: done follows a result column
  a_r6_done_after_column: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(cValid));

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the stationary operand does not move during a run
  a_r8_a_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(aView));

  // R9: start during a run keeps the run active
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !accept) |=> busy);

endmodule

bind matmul_array matmul_chk #(.N(N), .DW(DW)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .accept (accept),
  .cValid (cValid),
  .done   (done),
  .aView  (aView)
);

// File: tb/matmul_array_tb_top.sv
module matmul_array_tb_top;

  localparam int N  = 3;
  localparam int DW = 8;
  localparam int OW = 2 * DW + $clog2(N);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadA = 1'b0;
  logic              start = 1'b0;
  logic              bValid = 1'b0;
  logic [N*N*DW-1:0] aIn = '0;
  logic [N*DW-1:0]   bIn = '0;
  logic              cValid;
  logic              done;
  logic [N*OW-1:0]   cOut;

  always #4 clk = ~clk;

  matmul_array #(.N(N), .DW(DW)) dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .loadA  (loadA),
    .aIn    (aIn),
    .start  (start),
    .bValid (bValid),
    .bIn    (bIn),
    .cValid (cValid),
    .cOut   (cOut),
    .done   (done)
  );

  int    cyc = 0;
  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string tag = "R1";

  int refA   [N][N];
  int stageA [N][N];
  int bVec   [N];
  bit armed = 0;
  int cnt = 0;
  int expDue[$];
  int expVal[$];
  int doneDue[$];
  bit expNow;
  bit doneNow;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int rnd8();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // One input cycle plus the bench's own model of acceptance.
  task automatic step(bit ld, bit st, bit bv);
    bit wasArmed;
    bit acc;
    int sum;
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        aIn[(i*N+j)*DW +: DW] = DW'(stageA[i][j]);
    for (int j = 0; j < N; j++)
      bIn[j*DW +: DW] = DW'(bVec[j]);
    loadA  = ld;
    start  = st;
    bValid = bv;
    wasArmed = armed;
    acc = bv && wasArmed;
    if (ld && !wasArmed)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          refA[i][j] = stageA[i][j];
    if (acc) begin
      for (int i = 0; i < N; i++) begin
        sum = 0;
        for (int j = 0; j < N; j++) sum += refA[i][j] * bVec[j];
        expVal.push_back(sum);
      end
      expDue.push_back(cyc + 2);
      cnt++;
      if (cnt == N) begin
        armed = 0;
        doneDue.push_back(cyc + 3);
      end
    end
    if (st && !wasArmed) begin
      armed = 1;
      cnt = 0;
    end
  endtask

  task automatic idle(int k);
    for (int n = 0; n < k; n++) step(0, 0, 0);
  endtask

  task automatic randB();
    for (int j = 0; j < N; j++) bVec[j] = rnd8();
  endtask

  task automatic randA();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) stageA[i][j] = rnd8();
  endtask

  task automatic fillA(int v);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) stageA[i][j] = v;
  endtask

  task automatic fillB(int v);
    for (int j = 0; j < N; j++) bVec[j] = v;
  endtask

  // Full run: optional load, start, N back-to-back columns, drain.
  task automatic runConst(int av, int bv);
    fillA(av);
    step(1, 0, 0);
    step(0, 1, 0);
    fillB(bv);
    for (int k = 0; k < N; k++) step(0, 0, 1);
    idle(4);
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      expNow = (expDue.size() > 0) && (expDue[0] == cyc);
      check(tag, int'(cValid), int'(expNow), "cValid");
      if (expNow) begin
        for (int i = 0; i < N; i++)
          check(tag, int'($signed(cOut[i*OW +: OW])), expVal.pop_front(), "c element");
        void'(expDue.pop_front());
      end
      doneNow = (doneDue.size() > 0) && (doneDue[0] == cyc);
      check(tag, int'(done), int'(doneNow), "done");
      if (doneNow) void'(doneDue.pop_front());
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 5000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL R5 watchdog actual=%0d expected=<5000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", int'(cValid), 0, "cValid in reset");
    check("R1", int'(done), 0, "done in reset");
    check("R1", int'(cOut == '0), 1, "cOut zero in reset");
    rstN = 1'b1;

    // R1: run with no load gives zero columns
    tag = "R1";
    step(0, 1, 0);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
    idle(4);

    // R4: back-to-back columns, random A
    tag = "R4";
    randA(); step(1, 0, 0); step(0, 1, 0);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
    idle(4);

    // R2: several random matrices
    tag = "R2";
    for (int t = 0; t < 6; t++) begin
      randA(); step(1, 1, 0);
      for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
      idle(3);
    end

    // R5: gaps between columns
    tag = "R5";
    randA(); step(1, 0, 0); step(0, 1, 0);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); idle(k + 1); end
    idle(4);

    // R3: extreme operand values
    tag = "R3";
    runConst(-128, -128);
    runConst(127, 127);
    runConst(-128, 127);
    runConst(127, -128);

    // R7: bValid while idle and in the start cycle
    tag = "R7";
    randA(); step(1, 0, 0);
    for (int k = 0; k < 3; k++) begin randB(); step(0, 0, 1); end
    randB(); step(0, 1, 1);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
    idle(4);

    // R8: load attempts during a run, then a run reusing the held A
    tag = "R8";
    randA(); step(1, 1, 0);
    randA(); randB(); step(1, 0, 1);
    randA(); randB(); step(1, 0, 1);
    randA(); randB(); step(1, 0, 1);
    idle(4);
    randA(); step(0, 1, 0);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
    idle(4);

    // R9: start during a run, then an extra column after the run
    tag = "R9";
    randA(); step(1, 1, 0);
    randB(); step(0, 0, 1);
    randB(); step(0, 1, 1);
    randB(); step(0, 1, 0);
    randB(); step(0, 0, 1);
    randB(); step(0, 0, 1);
    idle(5);

    // R6: a run whose done pulse is checked in isolation
    tag = "R6";
    randA(); step(1, 1, 0);
    for (int k = 0; k < N; k++) begin randB(); step(0, 0, 1); end
    idle(6);

    check("R5", expDue.size(), 0, "pending columns");
    check("R6", doneDue.size(), 0, "pending done");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule